// File: doc/BRIEF.md
# Vertical-Sync Clocked Identification Byte Streamer

This block sends identification bytes to a display host over one open-drain serial data line, using the monitor's vertical sync signal as the shift clock. Software writes each byte into a one-byte holding register over a small write-only register bus. At every rising edge of vertical sync, the block puts one bit on the data line. A frame is eight data bits, most significant bit first, followed by one null bit that is always 1. When a frame has gone out, the block copies the holding register into the shift register. It then reports that the holding register is free, through a ready flag and the interrupt line.

The block also watches the serial clock pin. A host that wants the bidirectional protocol pulls that pin low. The block records the high-to-low transition in a sticky flag and raises the interrupt. The actual mode change, and any timeout that returns to streaming, belong to software. Software drives the `modeTwo` input to take the streamer out of service.

Both pins are sampled through two-flip-flop synchronizers into the system clock domain, and their edges are detected after synchronization. The bus map is: address 0 is the holding register (all bits written), and address 1 is the status write, where bit 0 set to 1 clears the clock-fall flag.

Top module: `vsync_id_streamer`

## Requirements
- R1: The streamer is active only while `ifEnable` is 1 and `modeTwo` is 0. In that state, each rising edge of `vsyncIn` advances the line by exactly one bit. The new bit is visible on `sdaOe` after the third rising `clk` edge following the change of the pin.
- R2: A frame is 9 bits: data bit 7 down to data bit 0, then a null bit of value 1.
- R3: The first active vertical-sync edge after reset or after re-activation loads the holding register and shows data bit 7. The edge after each null bit loads the next byte in the same way.
- R4: Every load sets `readyFlag` and therefore `irq`.
- R5: A bus write to address 0 stores the byte and clears `readyFlag` on the next `clk` edge. If the write and a load fall in the same cycle, the write wins and `readyFlag` ends up 0.
- R6: If the holding register has not been written since the previous load, the next frame repeats the previous byte.
- R7: The data pin is open drain. `sdaOe`=1 pulls the line low and stands for a 0 bit. A 1 bit releases the line. `sclOe` is never asserted.
- R8: A high-to-low transition of `sclIn` while active sets the sticky `sclFallFlag`, and `irq` with it. Transitions while inactive are ignored.
- R9: A bus write to address 1 with bit 0 set clears `sclFallFlag`. With bit 0 clear, the write leaves the flag unchanged. A new fall in the same cycle wins over the clear.
- R10: While inactive, `sdaOe` is 0 and vertical-sync edges are ignored. The bit position is reset, so the next active edge starts a new frame at data bit 7.
- R11: After reset, `sdaOe`, `sclOe`, `readyFlag`, `sclFallFlag` and `irq` are all 0, and the holding register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ifEnable | input | 1 | Interface enable |
| modeTwo | input | 1 | 1 = bidirectional mode selected by software; the streamer is idle |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 = holding register, 1 = status clear |
| busWdata | input | 8 | Write data |
| vsyncIn | input | 1 | Vertical sync, used as the shift clock |
| sclIn | input | 1 | Serial clock pin level |
| sdaOe | output | 1 | Pull data line low when 1 |
| sclOe | output | 1 | Pull clock line low when 1 (held 0) |
| readyFlag | output | 1 | Holding register free for a new byte |
| sclFallFlag | output | 1 | Sticky clock-fall request |
| irq | output | 1 | `readyFlag` OR `sclFallFlag` |

## Verification
A pin change reaches a detected edge two `clk` edges later, and the resulting register update lands on the third edge. A bus write takes effect on the first edge. The driver therefore holds each vertical-sync or clock-pin level for four cycles and samples on the falling clock edge, after all of these updates have settled. For each vertical-sync pulse, the driver pushes the expected line level and ready state into a queue. These expectations come from a frame model kept in the bench. The monitor pops each entry and compares it against the outputs only once the full latency has passed.

// File: rtl/vstx_pkg.sv
package vstx_pkg;
  typedef struct packed {
    logic load;   // copy holding register into shift register
    logic shift;  // advance one bit
    logic flush;  // idle: release the line
  } dpCmd_t;
endpackage

// File: rtl/vstx_sync.sv
module vstx_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stageQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stageQ[0] <= RST_VAL;
          else       stageQ[0] <= din;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stageQ[i] <= RST_VAL;
          else       stageQ[i] <= stageQ[i-1];
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/vstx_ctrl.sv
module vstx_ctrl
  import vstx_pkg::*;
#(
  parameter int FRAME_W = 9,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic             vsSync,
  input  logic             sclSync,
  input  logic             holdWrite,
  input  logic             clrSclFall,
  output dpCmd_t           cmd,
  output logic [CNT_W-1:0] bitCnt,
  output logic             readyFlag,
  output logic             sclFallFlag
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic vsPrev, sclPrev, vsRise, sclFall;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      vsPrev  <= 1'b0;
      sclPrev <= 1'b1;
    end else begin
      vsPrev  <= vsSync;
      sclPrev <= sclSync;
    end

  assign vsRise  = vsSync & ~vsPrev;
  assign sclFall = ~sclSync & sclPrev;

  always_comb begin
    cmd.load  = active & vsRise & (bitCnt == LAST);
    cmd.shift = active & vsRise & (bitCnt != LAST);
    cmd.flush = ~active;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          bitCnt <= LAST;
    else if (!active)   bitCnt <= LAST;
    else if (cmd.load)  bitCnt <= '0;
    else if (cmd.shift) bitCnt <= bitCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         readyFlag <= 1'b0;
    else if (holdWrite) readyFlag <= 1'b0;
    else if (cmd.load)  readyFlag <= 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  sclFallFlag <= 1'b0;
    else if (active && sclFall) sclFallFlag <= 1'b1;
    else if (clrSclFall)        sclFallFlag <= 1'b0;

  AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load && !holdWrite |=> readyFlag); // R4
  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    holdWrite |=> !readyFlag); // R5
  AST_IDLE_RESTARTS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> bitCnt == LAST); // R10
  AST_FALL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    sclFallFlag && !clrSclFall |=> sclFallFlag); // R9
  AST_FALL_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !active && !sclFallFlag |=> !sclFallFlag); // R8
endmodule

// File: rtl/vstx_datapath.sv
module vstx_datapath
  import vstx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              holdWrite,
  input  logic [DATA_W-1:0] holdData,
  output logic              pullLow
);
  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         holdReg <= '0;
    else if (holdWrite) holdReg <= holdData;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          shiftReg <= '1;
    else if (cmd.flush) shiftReg <= '1;
    else if (cmd.load)  shiftReg <= {holdReg, 1'b1};
    else if (cmd.shift) shiftReg <= {shiftReg[FRAME_W-2:0], 1'b1};

  assign pullLow = ~shiftReg[FRAME_W-1];

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.load, cmd.shift, cmd.flush})); // R1
  AST_FLUSH_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> !pullLow); // R10
endmodule

// File: rtl/vsync_id_streamer.sv
module vsync_id_streamer
  import vstx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W = DATA_W + 1,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ifEnable,
  input  logic              modeTwo,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              vsyncIn,
  input  logic              sclIn,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              readyFlag,
  output logic              sclFallFlag,
  output logic              irq
);
  logic active, vsSync, sclSync, holdWrite, clrSclFall, pullLow;
  logic [CNT_W-1:0] bitCnt;
  dpCmd_t cmd;

  assign active     = ifEnable & ~modeTwo;
  assign holdWrite  = busWe & ~busAddr;
  assign clrSclFall = busWe & busAddr & busWdata[0];

  vstx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uVsSync (
    .clk(clk), .rstN(rstN), .din(vsyncIn), .dout(vsSync));
  vstx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync));

  vstx_ctrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .active(active), .vsSync(vsSync),
    .sclSync(sclSync), .holdWrite(holdWrite), .clrSclFall(clrSclFall),
    .cmd(cmd), .bitCnt(bitCnt), .readyFlag(readyFlag),
    .sclFallFlag(sclFallFlag));

  vstx_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .holdWrite(holdWrite),
    .holdData(busWdata), .pullLow(pullLow));

  assign sdaOe = active & pullLow;
  assign sclOe = 1'b0;
  assign irq   = readyFlag | sclFallFlag;

  AST_NULL_BIT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    active && bitCnt == CNT_W'(FRAME_W - 1) |-> !sdaOe); // R2
endmodule

// File: tb/vsync_id_streamer_test.sv
module vsync_id_streamer_test;
  localparam int PERIOD = 10;

  logic clk = 0, rstN = 0, ifEnable = 0, modeTwo = 0, busWe = 0, busAddr = 0;
  logic [7:0] busWdata = 0;
  logic vsyncIn = 0, sclIn = 1;
  logic sdaOe, sclOe, readyFlag, sclFallFlag, irq;

  vsync_id_streamer uut (
    .clk(clk), .rstN(rstN), .ifEnable(ifEnable), .modeTwo(modeTwo),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .vsyncIn(vsyncIn), .sclIn(sclIn), .sdaOe(sdaOe), .sclOe(sclOe),
    .readyFlag(readyFlag), .sclFallFlag(sclFallFlag), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] expQ[$];
  string tagQ[$];
  event sampleEv;

  int idxM = 8;
  logic [8:0] frameM = '1;
  logic [7:0] holdM = 0;
  bit readyM = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations once results are due
  initial forever begin
    @(sampleEv);
    while (expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(sdaOe === e[0], t, "sdaOe", int'(sdaOe), int'(e[0]));
      check(readyFlag === e[1], t, "readyFlag", int'(readyFlag), int'(e[1]));
    end
  end

  // driver: one vertical-sync pulse plus the expected outcome
  task automatic vsPulse(string tag);
    vsyncIn = 1; cyc(4);
    vsyncIn = 0; cyc(4);
    if (ifEnable && !modeTwo) begin
      if (idxM == 8) begin
        idxM = 0; frameM = {holdM, 1'b1}; readyM = 1;
      end else idxM++;
    end
    expQ.push_back({readyM, (ifEnable && !modeTwo) ? ~frameM[8-idxM] : 1'b0});
    tagQ.push_back(tag);
    ->sampleEv;
  endtask

  task automatic writeHold(logic [7:0] v);
    busWe = 1; busAddr = 0; busWdata = v; cyc(1);
    busWe = 0; holdM = v; readyM = 0; cyc(1);
    check(readyFlag == 0, "R5", "readyFlag after write", int'(readyFlag), 0);
  endtask

  task automatic writeStatus(logic [7:0] v);
    busWe = 1; busAddr = 1; busWdata = v; cyc(1);
    busWe = 0; cyc(1);
  endtask

  task automatic sclDip();
    sclIn = 0; cyc(4); sclIn = 1; cyc(4);
  endtask

  task automatic goIdle();
    idxM = 8; frameM = '1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    cyc(3);
    // R11 reset state
    check(sdaOe == 0, "R11", "sdaOe", int'(sdaOe), 0);
    check(readyFlag == 0, "R11", "readyFlag", int'(readyFlag), 0);
    check(sclFallFlag == 0, "R11", "sclFallFlag", int'(sclFallFlag), 0);
    check(irq == 0, "R11", "irq", int'(irq), 0);
    rstN = 1; cyc(2);

    vsPulse("R10 disabled ignores vsync");
    writeHold(8'hA5);
    ifEnable = 1; cyc(2);

    // R1 R2 R3 R4: first frame, switch byte mid-frame (R5)
    for (int i = 0; i < 9; i++) begin
      vsPulse(i == 0 ? "R3 first load" : "R2 frame bit");
      if (i == 0) check(irq == 1, "R4", "irq after load", int'(irq), 1);
      if (i == 4) writeHold(8'h3C);
    end
    for (int i = 0; i < 9; i++) vsPulse("R1 second frame");
    for (int i = 0; i < 9; i++) vsPulse("R6 resend");
    check(sclOe == 0, "R7", "sclOe", int'(sclOe), 0);

    // mid-frame leave of mode 1
    for (int i = 0; i < 3; i++) vsPulse("R2 partial");
    modeTwo = 1; goIdle(); cyc(2);
    check(sdaOe == 0, "R10", "sdaOe idle", int'(sdaOe), 0);
    vsPulse("R10 mode two ignores vsync");
    sclDip();
    check(sclFallFlag == 0, "R8", "flag while idle", int'(sclFallFlag), 0);
    modeTwo = 0; cyc(2);

    sclDip();
    check(sclFallFlag == 1, "R8", "flag after fall", int'(sclFallFlag), 1);
    writeHold(8'h81);
    check(irq == 1, "R8", "irq from flag", int'(irq), 1);
    writeStatus(8'h00);
    check(sclFallFlag == 1, "R9", "flag kept", int'(sclFallFlag), 1);
    writeStatus(8'h01);
    check(sclFallFlag == 0, "R9", "flag cleared", int'(sclFallFlag), 0);
    check(irq == 0, "R9", "irq after clear", int'(irq), 0);

    for (int i = 0; i < 9; i++) vsPulse("R10 restart frame");
    check(sclOe == 0, "R7", "sclOe end", int'(sclOe), 0);
    cyc(2);
    finishRun();
  end
endmodule